// File: doc/BRIEF.md
# End-of-Task Interrupt Router

This block drives one interrupt line toward the host CPU for each of the coprocessor's eight tasks. In the normal case a line pulses for a single cycle after the coprocessor reports that the matching task has completed. The running task reports completion with `task_done` and identifies itself with `run_idx`.

The coprocessor can take any line over in software. It keeps a per-task software-interrupt enable mask. While a task's enable bit is set, that task's own completion no longer reaches its line. Any running task can then raise that line, or any other line, by writing a bit mask to the force register. Force bits clear themselves, so each accepted force write produces one pulse per set bit.

Both registers are written through a single write port. A source flag on that port marks accesses that came from the host side, and those accesses are dropped.

Top module: `eot_irq_router`

## Requirements
- R1: After synchronous reset, every line of `eot_irq` is 0 and the enable mask is all zeros, so every task starts with normal completion behaviour.
- R2: When `task_done` is 1 at clock edge k, and bit `run_idx` of the enable mask is 0, line `run_idx` is 1 for exactly the cycle after edge k+1.
- R3: When `task_done` is 1 and bit `run_idx` of the enable mask is 1, no line rises because of that completion.
- R4: An accepted write with `wr_op` = 2'b10 (force) at edge k drives `eot_irq` equal to `wr_mask` for the cycle after edge k+1. This holds whatever the enable mask holds and whatever task is running.
- R5: Force bits clear themselves: each accepted force write gives a one-cycle pulse. Back-to-back force writes give back-to-back pulses that follow each write's mask.
- R6: Writes with `wr_host` = 1 change neither the enable mask nor the force register.
- R7: `wr_op` = 2'b00 sets the enable bits selected by `wr_mask`, and `wr_op` = 2'b01 clears them. Unselected bits keep their value. A mask of 8'hFF covers all eight tasks.
- R8: A completion and a force for the same line at the same edge give one pulse, one cycle long.
- R9: `wr_op` = 2'b11 changes no state and raises no line.
- R10: A completion is judged against the enable mask as it stood before any enable write at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_host | input | 1 | 1 when the write came from the host side (ignored) |
| wr_op | input | 2 | 00 set enable bits, 01 clear enable bits, 10 force, 11 none |
| wr_mask | input | 8 | Per-task bit mask for the write |
| task_done | input | 1 | Completion pulse from the running task |
| run_idx | input | 3 | Index of the currently running task |
| eot_irq | output | 8 | End-of-task interrupt lines, one per task |

## Verification
The hardest situation to reach is a completion and an enable write at the same clock edge, because the result depends on which value of the enable mask the completion sees. The bench builds this case deliberately: it issues a set-enable write in the same cycle as a completion, then repeats the completion alone. The same timing is used for coincident force-plus-completion and for back-to-back force writes. Beyond that, the bench runs all 256 force masks and every task under both enable states.

// File: rtl/eot_pkg.sv
package eot_pkg;

    localparam int unsigned EOT_TASKS_DFLT = 8;

    typedef enum logic [1:0] {
        OP_EN_SET = 2'b00,
        OP_EN_CLR = 2'b01,
        OP_FORCE  = 2'b10,
        OP_NONE   = 2'b11
    } wr_op_e;

    typedef struct packed {
        logic   valid;
        logic   host;
        wr_op_e op;
    } wr_ctl_t;

    function automatic logic wr_accepted(input wr_ctl_t c);
        return c.valid && !c.host;
    endfunction

    function automatic logic is_op(input wr_ctl_t c, input wr_op_e op);
        return wr_accepted(c) && (c.op == op);
    endfunction

endpackage

// File: rtl/eot_cfg_regs.sv
module eot_cfg_regs
    import eot_pkg::*;
#(
    parameter int unsigned NUM_TASKS = EOT_TASKS_DFLT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  wr_ctl_t              ctl,
    input  logic [NUM_TASKS-1:0] mask,
    output logic [NUM_TASKS-1:0] swi_en,
    output logic [NUM_TASKS-1:0] force_pulse
);

    logic [NUM_TASKS-1:0] en_q;
    logic [NUM_TASKS-1:0] en_d;
    logic [NUM_TASKS-1:0] frc_q;

    always_comb begin
        en_d = en_q;
        if (is_op(ctl, OP_EN_SET)) begin
            en_d = en_q | mask;
        end else if (is_op(ctl, OP_EN_CLR)) begin
            en_d = en_q & ~mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            frc_q <= '0;
        end else begin
            en_q  <= en_d;
            frc_q <= is_op(ctl, OP_FORCE) ? mask : '0;
        end
    end

    assign swi_en      = en_q;
    assign force_pulse = frc_q;

endmodule

// File: rtl/eot_done_decode.sv
module eot_done_decode #(
    parameter int unsigned NUM_TASKS = 8,
    localparam int unsigned IDX_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 task_done,
    input  logic [IDX_W-1:0]     run_idx,
    input  logic [NUM_TASKS-1:0] swi_en,
    output logic [NUM_TASKS-1:0] done_pulse
);

    logic [NUM_TASKS-1:0] hit;
    logic [NUM_TASKS-1:0] done_q;

    for (genvar i = 0; i < NUM_TASKS; i++) begin : g_dec
        assign hit[i] = task_done && (run_idx == IDX_W'(i)) && !swi_en[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= '0;
        end else begin
            done_q <= hit;
        end
    end

    assign done_pulse = done_q;

endmodule

// File: rtl/eot_irq_merge.sv
module eot_irq_merge #(
    parameter int unsigned NUM_TASKS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_TASKS-1:0] done_pulse,
    input  logic [NUM_TASKS-1:0] force_pulse,
    output logic [NUM_TASKS-1:0] irq
);

    logic [NUM_TASKS-1:0] irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else begin
            irq_q <= done_pulse | force_pulse;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/eot_irq_router.sv
module eot_irq_router
    import eot_pkg::*;
#(
    parameter int unsigned NUM_TASKS = EOT_TASKS_DFLT,
    localparam int unsigned IDX_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_host,
    input  logic [1:0]           wr_op,
    input  logic [NUM_TASKS-1:0] wr_mask,
    input  logic                 task_done,
    input  logic [IDX_W-1:0]     run_idx,
    output logic [NUM_TASKS-1:0] eot_irq
);

    wr_ctl_t              ctl;
    logic [NUM_TASKS-1:0] swi_en;
    logic [NUM_TASKS-1:0] force_pulse;
    logic [NUM_TASKS-1:0] done_pulse;

    assign ctl.valid = wr_en;
    assign ctl.host  = wr_host;
    assign ctl.op    = wr_op_e'(wr_op);

    eot_cfg_regs #(.NUM_TASKS(NUM_TASKS)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .mask        (wr_mask),
        .swi_en      (swi_en),
        .force_pulse (force_pulse)
    );

    eot_done_decode #(.NUM_TASKS(NUM_TASKS)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .task_done  (task_done),
        .run_idx    (run_idx),
        .swi_en     (swi_en),
        .done_pulse (done_pulse)
    );

    eot_irq_merge #(.NUM_TASKS(NUM_TASKS)) u_merge (
        .clk         (clk),
        .rst         (rst),
        .done_pulse  (done_pulse),
        .force_pulse (force_pulse),
        .irq         (eot_irq)
    );

endmodule

// File: rtl/eot_irq_router_chk.sv
module eot_irq_router_chk #(
    parameter int unsigned NUM_TASKS = 8,
    localparam int unsigned IDX_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic                 wr_host,
    input logic [1:0]           wr_op,
    input logic [NUM_TASKS-1:0] wr_mask,
    input logic                 task_done,
    input logic [IDX_W-1:0]     run_idx,
    input logic [NUM_TASKS-1:0] eot_irq
);

    logic                 cop_wr;
    logic                 frc_wr;
    logic [NUM_TASKS-1:0] en_sh;

    assign cop_wr = wr_en && !wr_host;
    assign frc_wr = cop_wr && (wr_op == 2'b10);

    // independent shadow of the enable mask, built from port activity only
    always_ff @(posedge clk) begin
        if (rst) begin
            en_sh <= '0;
        end else if (cop_wr && wr_op == 2'b00) begin
            en_sh <= en_sh | wr_mask;
        end else if (cop_wr && wr_op == 2'b01) begin
            en_sh <= en_sh & ~wr_mask;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> eot_irq == '0);

    a_r4_force_reaches: assert property (@(posedge clk) disable iff (rst)
        frc_wr |-> ##2 ((eot_irq & $past(wr_mask, 2)) == $past(wr_mask, 2)));

    for (genvar i = 0; i < NUM_TASKS; i++) begin : g_line
        a_r2_done_reaches: assert property (@(posedge clk) disable iff (rst)
            (task_done && run_idx == IDX_W'(i) && !en_sh[i]) |-> ##2 eot_irq[i]);

        // R3, R6, R9: a line only rises for an unmasked completion or an accepted force
        a_r3_line_has_cause: assert property (@(posedge clk) disable iff (rst)
            eot_irq[i] |->
                ($past(frc_wr, 2) && $past(wr_mask[i], 2)) ||
                ($past(task_done, 2) && $past(run_idx, 2) == IDX_W'(i) && !$past(en_sh[i], 2)));
    end

endmodule

bind eot_irq_router eot_irq_router_chk #(.NUM_TASKS(NUM_TASKS)) u_eot_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_host   (wr_host),
    .wr_op     (wr_op),
    .wr_mask   (wr_mask),
    .task_done (task_done),
    .run_idx   (run_idx),
    .eot_irq   (eot_irq)
);

// File: tb/test_eot_irq_router.sv
`timescale 1ns/1ps
module test_eot_irq_router;

    localparam int unsigned N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic         wr_host = 1'b0;
    logic [1:0]   wr_op = 2'b11;
    logic [N-1:0] wr_mask = '0;
    logic         task_done = 1'b0;
    logic [2:0]   run_idx = '0;
    logic [N-1:0] eot_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    eot_irq_router #(.NUM_TASKS(N)) i_eot_irq_router (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_host(wr_host), .wr_op(wr_op),
        .wr_mask(wr_mask), .task_done(task_done), .run_idx(run_idx), .eot_irq(eot_irq)
    );

    task automatic check(input logic [N-1:0] exp, input string req);
        n_chk++;
        if (eot_irq !== exp) begin
            n_fail++;
            $display("FAIL %s: eot_irq actual %h expected %h", req, eot_irq, exp);
        end
    endtask

    // present stimulus for one clock edge, then return to idle
    task automatic drive(input logic done, input logic [2:0] idx, input logic we,
                         input logic host, input logic [1:0] op, input logic [N-1:0] m);
        task_done = done; run_idx = idx; wr_en = we; wr_host = host; wr_op = op; wr_mask = m;
        @(negedge clk);
        task_done = 1'b0; wr_en = 1'b0; wr_host = 1'b0; wr_op = 2'b11; wr_mask = '0;
    endtask

    // one pulse equal to exp, then quiet
    task automatic expect_pulse(input logic [N-1:0] exp, input string req);
        @(negedge clk); check(exp, req);
        @(negedge clk); check('0, req);
    endtask

    task automatic en_write(input logic host, input logic [1:0] op, input logic [N-1:0] m);
        drive(1'b0, 3'd0, 1'b1, host, op, m);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check('0, "R1");
        @(negedge clk); check('0, "R1");

        // R1 R2: enable mask starts cleared, every completion reaches its line
        for (int t = 0; t < N; t++) begin
            drive(1'b1, 3'(t), 1'b0, 1'b0, 2'b11, '0);
            expect_pulse(N'(1) << t, "R2");
        end

        // R7 R3: set all enables, completions are blocked
        en_write(1'b0, 2'b00, 8'hFF);
        for (int t = 0; t < N; t++) begin
            drive(1'b1, 3'(t), 1'b0, 1'b0, 2'b11, '0);
            expect_pulse('0, "R3");
        end

        // R7: clear lower half only
        en_write(1'b0, 2'b01, 8'h0F);
        for (int t = 0; t < N; t++) begin
            drive(1'b1, 3'(t), 1'b0, 1'b0, 2'b11, '0);
            expect_pulse((t < 4) ? (N'(1) << t) : '0, "R7");
        end

        // R4 R5: every force mask, with upper half enabled and various running tasks
        for (int m = 0; m < 256; m++) begin
            drive(1'b0, 3'(m % 8), 1'b1, 1'b0, 2'b10, 8'(m));
            expect_pulse(8'(m), "R4");
        end

        // R5: back-to-back force writes
        drive(1'b0, 3'd1, 1'b1, 1'b0, 2'b10, 8'hA5);
        drive(1'b0, 3'd1, 1'b1, 1'b0, 2'b10, 8'h3C);
        check(8'hA5, "R5");
        @(negedge clk); check(8'h3C, "R5");
        @(negedge clk); check('0, "R5");

        // R8: completion and force on the same line in the same cycle
        en_write(1'b0, 2'b01, 8'hFF);
        for (int t = 0; t < N; t++) begin
            drive(1'b1, 3'(t), 1'b1, 1'b0, 2'b10, (N'(1) << t) | 8'h01);
            expect_pulse((N'(1) << t) | 8'h01, "R8");
        end

        // R6: host writes change nothing
        en_write(1'b1, 2'b00, 8'hFF);
        drive(1'b1, 3'd5, 1'b0, 1'b0, 2'b11, '0);
        expect_pulse(8'h20, "R6");
        drive(1'b0, 3'd0, 1'b1, 1'b1, 2'b10, 8'hFF);
        expect_pulse('0, "R6");
        en_write(1'b0, 2'b00, 8'h80);
        en_write(1'b1, 2'b01, 8'hFF);
        drive(1'b1, 3'd7, 1'b0, 1'b0, 2'b11, '0);
        expect_pulse('0, "R6");
        en_write(1'b0, 2'b01, 8'hFF);

        // R9: op 11 is inert
        drive(1'b0, 3'd0, 1'b1, 1'b0, 2'b11, 8'hFF);
        expect_pulse('0, "R9");
        drive(1'b1, 3'd3, 1'b0, 1'b0, 2'b11, '0);
        expect_pulse(8'h08, "R9");

        // R10: enable write at the same edge as the completion sees the old mask
        drive(1'b1, 3'd2, 1'b1, 1'b0, 2'b00, 8'h04);
        expect_pulse(8'h04, "R10");
        drive(1'b1, 3'd2, 1'b0, 1'b0, 2'b11, '0);
        expect_pulse('0, "R10");
        drive(1'b1, 3'd2, 1'b1, 1'b0, 2'b01, 8'h04);
        expect_pulse('0, "R10");
        drive(1'b1, 3'd2, 1'b0, 1'b0, 2'b11, '0);
        expect_pulse(8'h04, "R10");

        // R1: reset clears the enable mask again
        en_write(1'b0, 2'b00, 8'hFF);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check('0, "R1");
        drive(1'b1, 3'd6, 1'b0, 1'b0, 2'b11, '0);
        expect_pulse(8'h40, "R1");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule